// File: doc/BRIEF.md
# Gated Pulse Accumulator Counter

This block measures how long an external timing input spends at its active level. The raw pin is sampled every second system clock through a two-stage synchronizer. A digital filter follows and removes noise pulses shorter than a programmed number of samples. The filtered level gates an accumulator. The accumulator advances once for every eight system clocks during which counting is enabled and the gate stays open.

The filter has two submodes. The stability submode accepts a new level only after that level has been seen on a programmed number of consecutive samples. The bypass submode passes each synchronized sample straight through. A polarity bit selects whether the gate opens on a high or a low filtered level. The accumulator wraps to zero on overflow and raises a sticky flag. A synchronous clear resets both of them.

Top module: `gated_pulse_acc`

## Requirements
- R1: After reset, `count_q` is 0, `ovf_q` is 0 and `level_q` is 0.
- R2: In bypass submode (`filt_mode`=1), `level_q` takes the synchronized pin value at each sample point, no more than 6 clocks after a change at the pin.
- R3: In stability submode (`filt_mode`=0), `level_q` changes only after the opposite value has been seen on W consecutive samples, where W = `filt_width` and a width of 0 acts as 1. Shorter pulses never reach `level_q`.
- R4: Samples are taken every second system clock, and `level_q` never changes on the clock after a non-sample cycle.
- R5: The gate is open when `level_q` equals `gate_pol` (1 means active-high, 0 means active-low). While the gate is closed, `count_q` does not advance.
- R6: With `count_en` high and the gate open, `count_q` increases by exactly one every 8 clocks. The first step comes on the 8th rising edge after a clear, or after `count_en` rises.
- R7: While `count_en` is low, `count_q` holds its value and the divide-by-eight prescaler is reset.
- R8: A step from the all-ones value wraps `count_q` to 0 and sets `ovf_q`, which then stays at 1 until a clear.
- R9: `clear` sets `count_q` and `ovf_q` to 0 and restarts the prescaler on the next edge. It takes priority over any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw external gate input |
| filt_mode | input | 1 | Filter submode: 0 stability, 1 bypass |
| filt_width | input | FW_W | Required run of equal samples in stability submode |
| gate_pol | input | 1 | Active level of the gate |
| count_en | input | 1 | Counting enable |
| clear | input | 1 | Synchronous clear of counter, flag and prescaler |
| count_q | output | CNT_W | Accumulated count |
| ovf_q | output | 1 | Sticky overflow flag |
| level_q | output | 1 | Filtered input level |

## Verification
The hardest situation to reach is the wrap of the accumulator. At the default width it takes more than a hundred million clocks of open gate. The bench therefore instantiates the block with a 10-bit counter, holds the gate open for just over 8192 clocks, and checks both the wrapped value and the sticky flag. It then checks that a clear removes the flag. The filter's reject boundary is reached with pulses sized in whole sample periods just below and above the programmed run. A long stretch of random pin toggling exercises sample-phase alignment against the reference model on every clock.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  typedef enum logic {
    FILT_STABLE = 1'b0,
    FILT_BYPASS = 1'b1
  } filt_mode_e;
endpackage

// File: rtl/gpa_sync.sv
module gpa_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic smp_stb,
  output logic smp_val
);
  logic phase;
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        s1 <= pin_in;
        s2 <= s1;
      end
    end
  end

  assign smp_stb = phase;
  assign smp_val = s2;

  // R4: the sample strobe alternates every clock
  assert_strobe_alternates_R4: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);
endmodule

// File: rtl/gpa_filter.sv
module gpa_filter
  import gpa_pkg::*;
#(
  parameter int FW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_stb,
  input  logic            smp_val,
  input  filt_mode_e      mode,
  input  logic [FW_W-1:0] width,
  output logic            level
);
  localparam int RW = FW_W + 1;

  logic [FW_W-1:0] run;
  logic [RW-1:0]   need;
  logic [RW-1:0]   run_next;

  always_comb begin
    need     = (width == '0) ? RW'(1) : {1'b0, width};
    run_next = {1'b0, run} + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      run   <= '0;
    end else if (smp_stb) begin
      if (mode == FILT_BYPASS) begin
        level <= smp_val;
        run   <= '0;
      end else if (smp_val == level) begin
        run <= '0;
      end else if (run_next >= need) begin
        level <= smp_val;
        run   <= '0;
      end else begin
        run <= run_next[FW_W-1:0];
      end
    end
  end

  assert_level_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(level));
  assert_stable_agrees_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == FILT_STABLE && smp_val == level) |=> $stable(level));
  assert_bypass_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == FILT_BYPASS && smp_stb) |=> level == $past(smp_val));
endmodule

// File: rtl/gpa_accum.sv
module gpa_accum #(
  parameter int CNT_W   = 24,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             gate,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre;
  logic             step;

  assign step = en && gate && (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (!en) begin
      pre <= '0;
    end else begin
      pre <= (pre == PRE_LAST) ? '0 : pre + PRE_W'(1);
      if (step) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == '1) ovf <= 1'b1;
      end
    end
  end

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (rst)
    (!gate && !clr) |=> $stable(cnt));
  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt != '1) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && gate && pre == PRE_LAST && cnt == '1) |=> (cnt == '0 && ovf));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/gated_pulse_acc.sv
module gated_pulse_acc
  import gpa_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int FW_W    = 8,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             filt_mode,
  input  logic [FW_W-1:0]  filt_width,
  input  logic             gate_pol,
  input  logic             count_en,
  input  logic             clear,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             level_q
);
  logic smp_stb, smp_val, lvl, gate_open;

  gpa_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_in  (pin_in),
    .smp_stb (smp_stb),
    .smp_val (smp_val)
  );

  gpa_filter #(.FW_W(FW_W)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .smp_val (smp_val),
    .mode    (filt_mode_e'(filt_mode)),
    .width   (filt_width),
    .level   (lvl)
  );

  assign gate_open = (lvl == gate_pol);

  gpa_accum #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_accum (
    .clk  (clk),
    .rst  (rst),
    .en   (count_en),
    .clr  (clear),
    .gate (gate_open),
    .cnt  (count_q),
    .ovf  (ovf_q)
  );

  assign level_q = lvl;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count_q == '0 && !ovf_q && !level_q));
endmodule

// File: tb/gated_pulse_acc_bench.sv
module gated_pulse_acc_bench;
  localparam int CW = 10;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_in = 1'b0;
  logic          filt_mode = 1'b1;
  logic [FW-1:0] filt_width = '0;
  logic          gate_pol = 1'b1;
  logic          count_en = 1'b0;
  logic          clear = 1'b0;
  logic [CW-1:0] count_q;
  logic          ovf_q;
  logic          level_q;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gated_pulse_acc #(.CNT_W(CW), .FW_W(FW), .PRE_DIV(8)) u_gated_pulse_acc (
    .clk(clk), .rst(rst), .pin_in(pin_in), .filt_mode(filt_mode),
    .filt_width(filt_width), .gate_pol(gate_pol), .count_en(count_en),
    .clear(clear), .count_q(count_q), .ovf_q(ovf_q), .level_q(level_q)
  );

  // behavioural reference: samples queued by pin history, integer counters
  int  m_clk = 0;
  bit  m_hist[$];
  bit  m_lvl = 0;
  int  m_run = 0;
  int  m_pre = 0;
  int  m_cnt = 0;
  bit  m_ovf = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_clk = 0; m_hist.delete(); m_lvl = 0; m_run = 0;
      m_pre = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      int need;
      bit smp;
      bit gate_ok;
      gate_ok = (m_lvl == gate_pol);
      // sample point: every odd clock since reset; filter sees value two samples old
      if (m_clk % 2 == 1) begin
        smp = (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 1'b0;
        need = (filt_width == 0) ? 1 : int'(filt_width);
        if (filt_mode) begin
          m_lvl = smp; m_run = 0;
        end else if (smp == m_lvl) begin
          m_run = 0;
        end else if (m_run + 1 >= need) begin
          m_lvl = smp; m_run = 0;
        end else begin
          m_run++;
        end
        m_hist.push_back(pin_in);
        if (m_hist.size() > 4) void'(m_hist.pop_front());
      end
      m_clk++;
      if (clear) begin
        m_pre = 0; m_cnt = 0; m_ovf = 0;
      end else if (!count_en) begin
        m_pre = 0;
      end else begin
        if (m_pre == 7 && gate_ok) begin
          if (m_cnt == (1 << CW) - 1) begin m_cnt = 0; m_ovf = 1; end
          else m_cnt++;
        end
        m_pre = (m_pre + 1) % 8;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3/R2 level_q vs model", int'(level_q), int'(m_lvl));
      chk("R6 count_q vs model", int'(count_q), m_cnt);
      chk("R8 ovf_q vs model", int'(ovf_q), int'(m_ovf));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; tick(1); clear = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R1 reset count", int'(count_q), 0);
    chk("R1 reset ovf", int'(ovf_q), 0);
    chk("R1 reset level", int'(level_q), 0);

    // R2: bypass, level follows pin within 6 clocks
    pin_in = 1'b1; tick(7);
    chk("R2 bypass level high", int'(level_q), 1);
    // R4: samples only on every second clock, hold a few cycles
    tick(4);

    // R6: exact step rate after a clear
    count_en = 1'b1;
    do_clear();
    tick(80);
    chk("R6 ten steps in 80 clocks", int'(count_q), 10);

    // R7: disable holds count
    count_en = 1'b0; tick(50);
    chk("R7 hold while disabled", int'(count_q), 10);
    count_en = 1'b1; tick(8);
    chk("R7 first step 8 clocks after enable", int'(count_q), 11);

    // R5: active-low gate with high level does not count
    gate_pol = 1'b0; tick(100);
    chk("R5 closed gate holds", int'(count_q), 11);
    gate_pol = 1'b1;

    // R9: clear wins over a step
    do_clear();
    chk("R9 clear count", int'(count_q), 0);

    // R3: stability filter, width 4 (8 clocks)
    filt_mode = 1'b0; filt_width = 8'd4;
    pin_in = 1'b0; tick(30);
    chk("R3 settled low", int'(level_q), 0);
    pin_in = 1'b1; tick(6); pin_in = 1'b0; tick(20);
    chk("R3 short pulse rejected", int'(level_q), 0);
    pin_in = 1'b1; tick(20);
    chk("R3 long pulse passes", int'(level_q), 1);
    pin_in = 1'b0; tick(20);
    filt_width = 8'd0;
    pin_in = 1'b1; tick(8);
    chk("R3 width zero acts as one", int'(level_q), 1);

    // R4 and filter: random pin activity, compared to model every clock
    filt_width = 8'd3;
    for (int i = 0; i < 3000; i++) begin
      pin_in = 1'($urandom_range(0, 1));
      tick(int'($urandom_range(1, 9)));
    end
    filt_mode = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      pin_in = 1'($urandom_range(0, 1));
      gate_pol = 1'($urandom_range(0, 1));
      tick(int'($urandom_range(1, 5)));
    end

    // R8: wrap and sticky flag
    gate_pol = 1'b1; pin_in = 1'b1; count_en = 1'b1; tick(10);
    do_clear();
    tick(8200);
    chk("R8 wrapped value", int'(count_q), 1);
    chk("R8 overflow set", int'(ovf_q), 1);
    tick(40);
    chk("R8 overflow sticky", int'(ovf_q), 1);
    do_clear();
    chk("R9 clear drops overflow", int'(ovf_q), 0);
    tick(4);
    finish_run();
  end

  initial begin
    #(200000 * 4);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule